// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Engine

This block takes characters from a serial receiver and stores them in memory buffers. A ring of 8-byte descriptors in a small descriptor RAM describes the buffers. For each buffer the engine reads the current descriptor and checks that hardware owns it. It then loads a data pointer from the descriptor's buffer address and loads a byte down-counter from the configured maximum buffer length. Each incoming byte is written to the data memory port.

A buffer closes when the counter runs out, when a character carries end-of-frame, or when a receive error is flagged. On close the engine writes the used byte count and an updated status back to the descriptor, pulses a done interrupt and moves to the next descriptor. The ring has no length register. The descriptor whose wrap flag is set sends the engine back to the table base.

Software sets up the table base, the maximum length and the character width, then raises the receive enable. Clearing the enable returns the engine to idle, and the next enable restarts it at the table base.

Top module: `rxbd_rx_engine`

## Requirements
- R1: While the receive enable is low the engine is idle: no descriptor reads, no memory writes, busy and done low. After the enable rises, the first descriptor is fetched at the table base, with the low three bits of the configured base treated as zero.
- R2: Descriptor layout, with byte offsets from the descriptor start: +0 status half-word, +2 length half-word, +4 buffer address bits 31:16, +6 buffer address bits 15:0. After a descriptor with status bit 13 (wrap) set is closed, the next fetch is at the table base. Otherwise the next fetch is 8 bytes further on.
- R3: A table base written while the enable is high has no effect until the enable has been low.
- R4: Bytes of one buffer are written to consecutive addresses, starting at the buffer address from the descriptor.
- R5: With no end-of-frame or error, a buffer closes after exactly the maximum-length number of bytes, and that count is written to its length field.
- R6: A character with end-of-frame set is stored, and then the buffer closes with the count of bytes stored.
- R7: A character with the error flag set is not stored. The buffer closes with the count of bytes stored before it, and status bit 1 is set.
- R8: On close, status bit 15 (empty) is cleared and every other status bit is kept. The done output pulses high for exactly one cycle per closed buffer.
- R9: The maximum length is sampled only when a descriptor is accepted. A change made during a buffer applies from the next descriptor on.
- R10: With the wide-character input high, each character is written as two bytes, bits 7:0 first and then bits 15:8. Both bytes count against the length. If the count runs out after the first byte, the buffer closes and the second byte is dropped.
- R11: If a fetched descriptor has status bit 15 clear, busy goes high and no bytes are written. Each character arriving in this state is dropped and causes a fresh fetch of the same descriptor. Busy falls when a fetch finds bit 15 set.
- R12: The descriptor RAM returns read data one cycle after the read strobe. The engine reads the status, then address bits 31:16, then address bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable |
| cfg_base | input | BD_AW | Descriptor table base (byte address) |
| cfg_mrblr | input | LEN_W | Maximum receive buffer length in bytes |
| cfg_wide | input | 1 | Characters are wider than 8 bits |
| chr_valid | input | 1 | One character present this cycle |
| chr_data | input | 16 | Character value |
| chr_eof | input | 1 | Character ends the frame |
| chr_err | input | 1 | Receive error; character is discarded |
| bd_re | output | 1 | Descriptor RAM read strobe |
| bd_we | output | 1 | Descriptor RAM write strobe |
| bd_addr | output | BD_AW | Descriptor RAM byte address (half-word aligned) |
| bd_wdata | output | 16 | Descriptor RAM write data |
| bd_rdata | input | 16 | Descriptor RAM read data, one cycle after the strobe |
| mem_we | output | 1 | Data memory byte write strobe |
| mem_addr | output | MEM_AW | Data memory byte address |
| mem_wdata | output | 8 | Data memory byte |
| rx_busy | output | 1 | Current descriptor not owned by hardware |
| irq_done | output | 1 | One-cycle pulse when a buffer is closed |

## Verification
The bench fills buffers in several ways and checks each close reason against the length and status written back. Plain byte streams run the counter out, which separates count closes from early closes. End-of-frame and error characters end buffers part-way, which separates storing the closing character from discarding it. Wide characters test byte order and the case where the count runs out between the two halves. The bench also changes the maximum length and the table base while receiving, and meets a descriptor that software still owns. These runs separate values latched at descriptor boundaries from live ones, and check that wrapping returns to the old base.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_RD0,
      S_RD1,
      S_RD2,
      S_RD3,
      S_RUN,
      S_WLO,
      S_WHI,
      S_CLEN,
      S_CSTAT,
      S_HOLD
   } rx_state_e;

   localparam int EMPTY_BIT = 15;
   localparam int WRAP_BIT  = 13;
   localparam int ERR_BIT   = 1;
   localparam int BD_BYTES  = 8;
   localparam int OFS_LEN   = 2;
   localparam int OFS_AHI   = 4;
   localparam int OFS_ALO   = 6;

endpackage

// File: rtl/rxbd_cfg.sv
module rxbd_cfg #(
   parameter int BD_AW = 10,
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic [BD_AW-1:0] cfg_base,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic             take_len,
   output logic [BD_AW-1:0] base_q,
   output logic [LEN_W-1:0] len_q
);

   localparam int ALIGN_W = 3;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         len_q  <= '0;
      end else begin
         if (!rx_en)
            base_q <= {cfg_base[BD_AW-1:ALIGN_W], {ALIGN_W{1'b0}}};
         if (take_len)
            len_q <= cfg_len;
      end
   end

   AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && $past(rx_en)) |-> $stable(base_q)); // R3

   AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !take_len |=> $stable(len_q)); // R9

endmodule

// File: rtl/rxbd_track.sv
module rxbd_track #(
   parameter int MEM_AW = 32,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [MEM_AW-1:0] load_addr,
   input  logic [LEN_W-1:0]  load_len,
   input  logic              step,
   output logic [MEM_AW-1:0] dptr,
   output logic [LEN_W-1:0]  remain
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dptr   <= '0;
         remain <= '0;
      end else if (load) begin
         dptr   <= load_addr;
         remain <= load_len;
      end else if (step) begin
         dptr   <= dptr + 1'b1;
         remain <= remain - 1'b1;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> remain != '0); // R5

   AST_DPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> dptr == $past(dptr) + 1'b1); // R4

endmodule

// File: rtl/rxbd_rx_engine.sv
module rxbd_rx_engine
   import rxbd_pkg::*;
#(
   parameter int BD_AW        = 10,
   parameter int MEM_AW       = 32,
   parameter int LEN_W        = 16,
   parameter bit SUPPORT_WIDE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic [BD_AW-1:0]  cfg_base,
   input  logic [LEN_W-1:0]  cfg_mrblr,
   input  logic              cfg_wide,
   input  logic              chr_valid,
   input  logic [15:0]       chr_data,
   input  logic              chr_eof,
   input  logic              chr_err,
   output logic              bd_re,
   output logic              bd_we,
   output logic [BD_AW-1:0]  bd_addr,
   output logic [15:0]       bd_wdata,
   input  logic [15:0]       bd_rdata,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              rx_busy,
   output logic              irq_done
);

   localparam int PAD_W = 16 - LEN_W;

   if (BD_AW < 4) begin : g_bad_bdaw
      $error("BD_AW must be at least 4");
   end
   if (MEM_AW < 1 || MEM_AW > 32) begin : g_bad_memaw
      $error("MEM_AW must be between 1 and 32");
   end
   if (LEN_W < 2 || LEN_W > 16) begin : g_bad_lenw
      $error("LEN_W must be between 2 and 16");
   end

   rx_state_e         state;
   logic [BD_AW-1:0]  bd_ptr;
   logic [15:0]       stat_q;
   logic [15:0]       ahi_q;
   logic [15:0]       chr_q;
   logic              eof_q, err_q, wide_q, busy_q;
   logic              wide_en;
   logic              take_bd, step, closing;
   logic [BD_AW-1:0]  base_q;
   logic [LEN_W-1:0]  len_q;
   logic [MEM_AW-1:0] dptr;
   logic [LEN_W-1:0]  remain;
   logic [31:0]       buf_addr;
   logic [LEN_W-1:0]  used;

   if (SUPPORT_WIDE) begin : g_wide
      assign wide_en = cfg_wide;
   end else begin : g_narrow
      assign wide_en = 1'b0;
   end

   assign take_bd  = (state == S_RD3) && stat_q[EMPTY_BIT];
   assign step     = (state == S_WLO) || (state == S_WHI);
   assign closing  = (state == S_CLEN) || (state == S_CSTAT);
   assign buf_addr = {ahi_q, bd_rdata};
   assign used     = len_q - remain;

   rxbd_cfg #(.BD_AW(BD_AW), .LEN_W(LEN_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_en    (rx_en),
      .cfg_base (cfg_base),
      .cfg_len  (cfg_mrblr),
      .take_len (take_bd),
      .base_q   (base_q),
      .len_q    (len_q)
   );

   rxbd_track #(.MEM_AW(MEM_AW), .LEN_W(LEN_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (take_bd),
      .load_addr (buf_addr[MEM_AW-1:0]),
      .load_len  (cfg_mrblr),
      .step      (step),
      .dptr      (dptr),
      .remain    (remain)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         bd_ptr <= '0;
         stat_q <= '0;
         ahi_q  <= '0;
         chr_q  <= '0;
         eof_q  <= 1'b0;
         err_q  <= 1'b0;
         wide_q <= 1'b0;
         busy_q <= 1'b0;
      end else if (!rx_en && !closing) begin
         state  <= S_IDLE;
         busy_q <= 1'b0;
         err_q  <= 1'b0;
         bd_ptr <= base_q;
      end else begin
         case (state)
            S_IDLE: begin
               bd_ptr <= base_q;
               if (rx_en) state <= S_RD0;
            end
            S_RD0: state <= S_RD1;
            S_RD1: begin
               stat_q <= bd_rdata;
               state  <= S_RD2;
            end
            S_RD2: begin
               ahi_q <= bd_rdata;
               state <= S_RD3;
            end
            S_RD3: begin
               busy_q <= !stat_q[EMPTY_BIT];
               state  <= stat_q[EMPTY_BIT] ? S_RUN : S_HOLD;
            end
            S_RUN: begin
               if (chr_valid) begin
                  if (chr_err) begin
                     err_q <= 1'b1;
                     state <= S_CLEN;
                  end else begin
                     chr_q  <= chr_data;
                     eof_q  <= chr_eof;
                     wide_q <= wide_en;
                     state  <= S_WLO;
                  end
               end
            end
            S_WLO: begin
               if (remain == LEN_W'(1))  state <= S_CLEN;
               else if (wide_q)          state <= S_WHI;
               else if (eof_q)           state <= S_CLEN;
               else                      state <= S_RUN;
            end
            S_WHI: begin
               if (remain == LEN_W'(1) || eof_q) state <= S_CLEN;
               else                              state <= S_RUN;
            end
            S_CLEN: state <= S_CSTAT;
            S_CSTAT: begin
               err_q  <= 1'b0;
               bd_ptr <= stat_q[WRAP_BIT] ? base_q : bd_ptr + BD_AW'(BD_BYTES);
               state  <= rx_en ? S_RD0 : S_IDLE;
            end
            S_HOLD: if (chr_valid) state <= S_RD0;
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      bd_re    = 1'b0;
      bd_we    = 1'b0;
      bd_addr  = bd_ptr;
      bd_wdata = '0;
      case (state)
         S_RD0: bd_re = 1'b1;
         S_RD1: begin
            bd_re   = 1'b1;
            bd_addr = bd_ptr + BD_AW'(OFS_AHI);
         end
         S_RD2: begin
            bd_re   = 1'b1;
            bd_addr = bd_ptr + BD_AW'(OFS_ALO);
         end
         S_CLEN: begin
            bd_we    = 1'b1;
            bd_addr  = bd_ptr + BD_AW'(OFS_LEN);
            bd_wdata = {{PAD_W{1'b0}}, used};
         end
         S_CSTAT: begin
            bd_we    = 1'b1;
            bd_wdata = stat_q;
            bd_wdata[EMPTY_BIT] = 1'b0;
            if (err_q) bd_wdata[ERR_BIT] = 1'b1;
         end
         default: ;
      endcase
   end

   assign mem_we    = step;
   assign mem_addr  = dptr;
   assign mem_wdata = (state == S_WHI) ? chr_q[15:8] : chr_q[7:0];
   assign rx_busy   = busy_q;
   assign irq_done  = (state == S_CSTAT);

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done |=> !irq_done); // R8

   AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !rx_busy); // R11

   AST_WRAP_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_done && stat_q[WRAP_BIT]) |=> bd_ptr == $past(base_q)); // R2

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !closing) |=> !mem_we && !bd_re); // R1

endmodule

// File: tb/rxbd_rx_engine_test.sv
module rxbd_rx_engine_test;

   localparam int CLK_PER = 10;
   localparam int BD_AW   = 10;
   localparam int MEM_AW  = 32;
   localparam int LEN_W   = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rx_en = 1'b0;
   logic [BD_AW-1:0]  cfg_base = '0;
   logic [LEN_W-1:0]  cfg_mrblr = '0;
   logic              cfg_wide = 1'b0;
   logic              chr_valid = 1'b0;
   logic [15:0]       chr_data = '0;
   logic              chr_eof = 1'b0;
   logic              chr_err = 1'b0;
   logic              bd_re, bd_we;
   logic [BD_AW-1:0]  bd_addr;
   logic [15:0]       bd_wdata;
   logic [15:0]       bd_rdata = '0;
   logic              mem_we;
   logic [MEM_AW-1:0] mem_addr;
   logic [7:0]        mem_wdata;
   logic              rx_busy, irq_done;

   logic [15:0] bdram [0:63];
   logic        tb_we = 1'b0;
   logic [5:0]  tb_idx = '0;
   logic [15:0] tb_val = '0;

   int n_chk = 0;
   int n_bad = 0;
   int n_irq = 0;
   bit last_irq = 1'b0;
   bit done = 1'b0;
   logic [39:0] expq [$];

   always #(CLK_PER/2) clk = ~clk;

   rxbd_rx_engine #(.BD_AW(BD_AW), .MEM_AW(MEM_AW), .LEN_W(LEN_W)) uut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_base(cfg_base),
      .cfg_mrblr(cfg_mrblr), .cfg_wide(cfg_wide), .chr_valid(chr_valid),
      .chr_data(chr_data), .chr_eof(chr_eof), .chr_err(chr_err),
      .bd_re(bd_re), .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata),
      .bd_rdata(bd_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .rx_busy(rx_busy), .irq_done(irq_done)
   );

   // descriptor RAM model: one-cycle read latency (R12)
   always @(posedge clk) begin
      if (bd_re) bd_rdata <= bdram[bd_addr[6:1]];
      if (bd_we) bdram[bd_addr[6:1]] <= bd_wdata;
      if (tb_we) bdram[tb_idx] <= tb_val;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_we) begin
            n_chk++;
            if (expq.size() == 0) begin
               n_bad++;
               $display("FAIL R4/R11 unexpected write: actual %h@%h expected none",
                        mem_wdata, mem_addr);
            end else begin
               logic [39:0] e;
               e = expq.pop_front();
               if (e != {mem_addr, mem_wdata}) begin
                  n_bad++;
                  $display("FAIL R4 write: actual %h@%h expected %h@%h",
                           mem_wdata, mem_addr, e[7:0], e[39:8]);
               end
            end
         end
         if (irq_done) n_irq++;
         if (irq_done && last_irq) begin
            n_chk++; n_bad++;
            $display("FAIL R8 done pulse: actual 2 cycles expected 1");
         end
         last_irq = irq_done;
      end
   end

   task automatic poke(input int byte_addr, input logic [15:0] v);
      @(negedge clk);
      tb_we = 1'b1; tb_idx = 6'(byte_addr >> 1); tb_val = v;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   task automatic set_bd(input int b, input logic [15:0] st, input logic [31:0] a);
      poke(b, st);
      poke(b + 2, 16'h0000);
      poke(b + 4, a[31:16]);
      poke(b + 6, a[15:0]);
   endtask

   task automatic expect_byte(input logic [31:0] a, input logic [7:0] d);
      expq.push_back({a, d});
   endtask

   task automatic send(input logic [15:0] d, input logic eof, input logic err);
      @(negedge clk);
      chr_valid = 1'b1; chr_data = d; chr_eof = eof; chr_err = err;
      @(negedge clk);
      chr_valid = 1'b0; chr_eof = 1'b0; chr_err = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   function automatic int st_of(input int b);
      return int'(bdram[b >> 1]);
   endfunction
   function automatic int ln_of(input int b);
      return int'(bdram[(b >> 1) + 1]);
   endfunction

   initial begin
      #(CLK_PER * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      cfg_base  = 10'h010;
      cfg_mrblr = 16'd4;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      set_bd(16'h10, 16'h8010, 32'h2000_0100);
      set_bd(16'h18, 16'h8000, 32'h2000_0200);
      set_bd(16'h20, 16'hA000, 32'h2000_0300);
      set_bd(16'h30, 16'hA000, 32'h2000_0400);
      repeat (3) @(negedge clk);
      // R1: idle while disabled
      chk("R1 idle mem_we", mem_we, 0);
      chk("R1 idle bd_re", bd_re, 0);
      chk("R1 idle busy", rx_busy, 0);
      chk("R1 idle done", irq_done, 0);

      rx_en = 1'b1;
      repeat (10) @(negedge clk);

      // T1 R5: count close, R8 status keeps other bits
      for (int i = 0; i < 4; i++) begin
         expect_byte(32'h2000_0100 + i, 8'h11 + 8'(i));
         send(16'h0011 + 16'(i), 1'b0, 1'b0);
      end
      chk("R5 length BD0", ln_of(16'h10), 4);
      chk("R8 status BD0", st_of(16'h10), 16'h0010);
      chk("R8 done count", n_irq, 1);

      // R3: base change while enabled must not take effect
      cfg_base = 10'h033;

      // T2 R6: end-of-frame close
      expect_byte(32'h2000_0200, 8'h21);
      send(16'h0021, 1'b0, 1'b0);
      expect_byte(32'h2000_0201, 8'h22);
      send(16'h0022, 1'b1, 1'b0);
      chk("R6 length BD1", ln_of(16'h18), 2);
      chk("R6 status BD1", st_of(16'h18), 16'h0000);

      // T3 R9: new length during BD2 does not apply; R2 wrap; R11 busy
      cfg_mrblr = 16'd6;
      for (int i = 0; i < 4; i++) begin
         expect_byte(32'h2000_0300 + i, 8'h31 + 8'(i));
         send(16'h0031 + 16'(i), 1'b0, 1'b0);
      end
      send(16'h0035, 1'b0, 1'b0);  // dropped
      chk("R9 length BD2 old value", ln_of(16'h20), 4);
      chk("R2 status BD2 keeps wrap", st_of(16'h20), 16'h2000);
      chk("R2/R3 busy at old base", rx_busy, 1);

      set_bd(16'h10, 16'h8000, 32'h2000_0100);
      set_bd(16'h18, 16'h8000, 32'h2000_0200);
      set_bd(16'h20, 16'hA000, 32'h2000_0300);
      send(16'h0099, 1'b0, 1'b0);  // dropped, triggers refetch
      chk("R11 busy cleared", rx_busy, 0);

      // T4 R9: new length applies to next descriptor
      for (int i = 0; i < 6; i++) begin
         expect_byte(32'h2000_0100 + i, 8'h41 + 8'(i));
         send(16'h0041 + 16'(i), 1'b0, 1'b0);
      end
      chk("R9 length BD0 new value", ln_of(16'h10), 6);

      // T5 R7: error close
      expect_byte(32'h2000_0200, 8'h51);
      send(16'h0051, 1'b0, 1'b0);
      expect_byte(32'h2000_0201, 8'h52);
      send(16'h0052, 1'b0, 1'b0);
      send(16'h0053, 1'b0, 1'b1);
      chk("R7 length BD1", ln_of(16'h18), 2);
      chk("R7 status BD1", st_of(16'h18), 16'h0002);

      // T6 R10: wide characters, low byte first
      cfg_wide = 1'b1;
      for (int i = 0; i < 3; i++) begin
         expect_byte(32'h2000_0300 + 2*i,     8'h61 + 8'(2*i));
         expect_byte(32'h2000_0300 + 2*i + 1, 8'h62 + 8'(2*i));
         send({8'h62 + 8'(2*i), 8'h61 + 8'(2*i)}, 1'b0, 1'b0);
      end
      chk("R10 length BD2 wide", ln_of(16'h20), 6);
      chk("R11 busy after wrap", rx_busy, 1);

      // T7 R10: odd length closes between halves
      cfg_mrblr = 16'd3;
      set_bd(16'h10, 16'h8000, 32'h2000_0100);
      send(16'h0000, 1'b0, 1'b0);  // dropped, refetch latches 3
      expect_byte(32'h2000_0100, 8'h71);
      expect_byte(32'h2000_0101, 8'h72);
      send(16'h7271, 1'b0, 1'b0);
      expect_byte(32'h2000_0102, 8'h73);
      send(16'h7473, 1'b0, 1'b0);
      chk("R10 length odd", ln_of(16'h10), 3);

      // T8 R1/R3: disable, base takes effect, low bits ignored
      rx_en = 1'b0;
      cfg_wide = 1'b0;
      cfg_mrblr = 16'd4;
      repeat (4) @(negedge clk);
      chk("R1 busy cleared when disabled", rx_busy, 0);
      rx_en = 1'b1;
      repeat (10) @(negedge clk);
      expect_byte(32'h2000_0400, 8'h81);
      send(16'h0081, 1'b1, 1'b0);
      chk("R1 length at new base", ln_of(16'h30), 1);
      chk("R1 status at new base", st_of(16'h30), 16'h2000);

      chk("R8 total done pulses", n_irq, 8);
      chk("R4 scoreboard drained", expq.size(), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule